// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block sits on the device side of a parallel NOR flash model. It produces the bit-7 polling status that a host reads while an internal program or erase algorithm runs. Once a command has been fully written, the block hands a start pulse to the algorithm sequencer, or refuses to start it for a protected target. It then answers every read strobe one cycle later. Depending on its state and on whether the read address qualifies, it returns a status byte, array data or all ones.

A status byte has bit 7 set by the polling rule and bits 6..0 driven to zero, because the toggle bits are outside this block. For a program, bit 7 reads as the inverse of the data bit being written until the sequencer drops busy. For an erase, bit 7 reads 0 while erasing and 1 while the erase is suspended. A program to a protected sector, or an erase whose selected sectors are all protected, does not start the sequencer. It shows polling status for a fixed window of `CLK_MHZ*PGM_US` or `CLK_MHZ*ERS_US` cycles, 50 and 5000 by default, and then falls back to array reads.

The FSM states are `ST_IDLE`, `ST_PGM_RUN`, `ST_ERS_RUN`, `ST_ERS_SUSP`, `ST_SUSP_PGM`, `ST_FAKE_PGM` and `ST_FAKE_ERS`. Transitions:
- IDLE→PGM_RUN on an accepted program.
- IDLE→FAKE_PGM on a program to a protected sector.
- IDLE→ERS_RUN on an erase that has at least one unprotected sector.
- IDLE→FAKE_ERS on an erase with no unprotected sector.
- PGM_RUN→IDLE and ERS_RUN→IDLE when busy falls after having been seen high.
- ERS_RUN→ERS_SUSP when suspend is requested; this takes priority over completion.
- ERS_SUSP→SUSP_PGM on a program to an unprotected sector.
- SUSP_PGM→ERS_SUSP when busy falls after having been seen high.
- ERS_SUSP→ERS_RUN when suspend is released.
- FAKE_PGM→IDLE and FAKE_ERS→IDLE when the window timer expires.

Top module: `flash_poll_status`

## Requirements
- R1: After reset `rd_valid` and `alg_start` are 0. With no command in flight, and before any command is accepted, a read returns `array_data`.
- R2: During an accepted program, a read at the exact program address returns `{~cmd_dq7, 7'h00}`. Once busy has been seen high and then falls, reads return `array_data`.
- R3: During an erase, a read at a valid erase address returns 8'h00. Once busy has been seen high and then falls, reads return `array_data`.
- R4: While the erase is suspended, a read at a valid erase address returns 8'h80, and a read at any other address returns `array_data`.
- R5: A program accepted during erase suspend pulses `alg_start` with `alg_is_erase`=0. It reads `{~cmd_dq7, 7'h00}` at its address, and when its busy ends the block returns to suspend status (8'h80).
- R6: A program to a protected sector does not pulse `alg_start`. It reads status at its address for exactly `CLK_MHZ*PGM_US` cycles after acceptance, then array data.
- R7: An erase with no unprotected selected sector does not pulse `alg_start`. It reads 8'h00 at selected sectors for exactly `CLK_MHZ*ERS_US` cycles, then array data.
- R8: An accepted erase pulses `alg_start` with `alg_is_erase`=1 and `alg_sec_mask` = the selected sectors minus the protected ones. For a chip erase, the selected sectors are all sectors.
- R9: The sector is `addr[AW-1 -: log2(NSEC)]`. A sector erase qualifies reads in any selected sector. A chip erase qualifies reads in unprotected sectors only. An unqualified read during a busy state returns 8'hFF.
- R10: Every read strobe is answered with `rd_valid` exactly one cycle later, never stalled.
- R11: Commands arriving in a busy state are ignored. `cmd_kind` 2'b11 is ignored in every state. Encodings: 2'b00 program, 2'b01 sector erase, 2'b10 chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Final write strobe of a command sequence |
| cmd_kind | input | 2 | Command type (00 program, 01 sector erase, 10 chip erase) |
| cmd_addr | input | AW | Program address or erase address |
| cmd_dq7 | input | 1 | Bit 7 of the byte being programmed |
| sec_prot | input | NSEC | Per-sector protection flags |
| ers_sel | input | NSEC | Sectors selected for a sector erase |
| ers_susp | input | 1 | Erase-suspend request |
| seq_busy | input | 1 | Busy from the algorithm sequencer |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| array_data | input | 8 | Cell-array data for the read address |
| alg_start | output | 1 | One-cycle start pulse to the sequencer |
| alg_is_erase | output | 1 | Started algorithm is an erase |
| alg_sec_mask | output | NSEC | Sectors the erase really touches |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | 8 | Read answer |

## Verification
Programs are tried with bit 7 set and with bit 7 clear, so that inverse polling and true data read differently. Each is read at its own address and at a foreign address, which separates status from the all-ones answer. Erase patterns cover three cases:
- a sector erase whose selection includes a protected sector, which tests the start mask and the qualification of the protected but selected sector;
- a chip erase with one protected sector, where that sector must read all ones;
- an erase selecting only protected sectors.

Suspend is checked with reads at erase and non-erase sectors and with a program nested inside it. The protected-target cases are read on the last window cycle and on the first cycle after it, which pins down the window length exactly.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [1:0] {
        CMD_PGM  = 2'b00,
        CMD_SERS = 2'b01,
        CMD_CERS = 2'b10,
        CMD_NONE = 2'b11
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGM_RUN,
        ST_ERS_RUN,
        ST_ERS_SUSP,
        ST_SUSP_PGM,
        ST_FAKE_PGM,
        ST_FAKE_ERS
    } fsm_st_e;

    localparam logic [6:0] STAT_LOW = 7'h00;
    localparam logic [7:0] RD_NONE  = 8'hFF;

endpackage

// File: rtl/fps_win_timer.sv
module fps_win_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/fps_addr_qual.sv
module fps_addr_qual #(
    parameter int AW   = 20,
    parameter int NSEC = 16,
    parameter int SW   = 4
) (
    input  logic [AW-1:0]   rd_addr,
    input  logic [AW-1:0]   pgm_addr,
    input  logic [NSEC-1:0] vmask,
    output logic            pgm_hit,
    output logic            ers_hit
);

    logic [NSEC-1:0] sec_onehot;
    logic [SW-1:0]   rd_sec;

    assign rd_sec = rd_addr[AW-1 -: SW];

    for (genvar s = 0; s < NSEC; s++) begin : g_dec
        assign sec_onehot[s] = (rd_sec == SW'(s));
    end

    assign ers_hit = |(sec_onehot & vmask);
    assign pgm_hit = (rd_addr == pgm_addr);

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
#(
    parameter int AW      = 20,
    parameter int NSEC    = 16,
    parameter int SW      = 4,
    parameter int CW      = 13,
    parameter int PGM_WIN = 50,
    parameter int ERS_WIN = 5000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_start,
    input  logic [1:0]      cmd_kind,
    input  logic [AW-1:0]   cmd_addr,
    input  logic            cmd_dq7,
    input  logic [NSEC-1:0] sec_prot,
    input  logic [NSEC-1:0] ers_sel,
    input  logic            ers_susp,
    input  logic            seq_busy,
    input  logic            rd_en,
    input  logic [7:0]      array_data,
    input  logic            pgm_hit,
    input  logic            ers_hit,
    input  logic            tmr_expired,
    output logic            tmr_load,
    output logic [CW-1:0]   tmr_val,
    output logic [AW-1:0]   paddr_q,
    output logic [NSEC-1:0] vmask_q,
    output logic            alg_start,
    output logic            alg_is_erase,
    output logic [NSEC-1:0] alg_sec_mask,
    output logic            rd_valid,
    output logic [7:0]      rd_data
);

    fsm_st_e         st_q, st_d;
    cmd_kind_e       kind;
    logic [SW-1:0]   tgt;
    logic            tgt_prot;
    logic [NSEC-1:0] eff_mask;
    logic            is_ers, idle_go;
    logic            acc_pgm, fake_pgm, acc_ers, fake_ers, acc_spgm;
    logic            pgm_seen_q, ers_seen_q, pbit_q;
    logic [7:0]      rd_val;
    logic [7:0]      pgm_stat;

    // command decode against the protection state
    always_comb begin
        kind     = cmd_kind_e'(cmd_kind);
        tgt      = cmd_addr[AW-1 -: SW];
        tgt_prot = sec_prot[tgt];
        is_ers   = (kind == CMD_SERS) || (kind == CMD_CERS);
        eff_mask = (kind == CMD_CERS) ? ~sec_prot : (ers_sel & ~sec_prot);
        idle_go  = (st_q == ST_IDLE) && cmd_start;
        acc_pgm  = idle_go && (kind == CMD_PGM) && !tgt_prot;
        fake_pgm = idle_go && (kind == CMD_PGM) && tgt_prot;
        acc_ers  = idle_go && is_ers && (eff_mask != '0);
        fake_ers = idle_go && is_ers && (eff_mask == '0);
        acc_spgm = (st_q == ST_ERS_SUSP) && cmd_start && (kind == CMD_PGM) && !tgt_prot;
    end

    assign tmr_load = fake_pgm | fake_ers;
    assign tmr_val  = fake_pgm ? CW'(PGM_WIN - 1) : CW'(ERS_WIN - 1);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (acc_pgm)       st_d = ST_PGM_RUN;
                else if (fake_pgm) st_d = ST_FAKE_PGM;
                else if (acc_ers)  st_d = ST_ERS_RUN;
                else if (fake_ers) st_d = ST_FAKE_ERS;
            end
            ST_PGM_RUN: begin
                if (pgm_seen_q && !seq_busy) st_d = ST_IDLE;
            end
            ST_ERS_RUN: begin
                if (ers_susp)                     st_d = ST_ERS_SUSP;
                else if (ers_seen_q && !seq_busy) st_d = ST_IDLE;
            end
            ST_ERS_SUSP: begin
                if (acc_spgm)      st_d = ST_SUSP_PGM;
                else if (!ers_susp) st_d = ST_ERS_RUN;
            end
            ST_SUSP_PGM: begin
                if (pgm_seen_q && !seq_busy) st_d = ST_ERS_SUSP;
            end
            ST_FAKE_PGM, ST_FAKE_ERS: begin
                if (tmr_expired) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // read answer selection
    always_comb begin
        pgm_stat = {~pbit_q, STAT_LOW};
        rd_val   = RD_NONE;
        unique case (st_q)
            ST_IDLE:                  rd_val = array_data;
            ST_PGM_RUN, ST_FAKE_PGM,
            ST_SUSP_PGM:              rd_val = pgm_hit ? pgm_stat : RD_NONE;
            ST_ERS_RUN, ST_FAKE_ERS:  rd_val = ers_hit ? {1'b0, STAT_LOW} : RD_NONE;
            ST_ERS_SUSP:              rd_val = ers_hit ? {1'b1, STAT_LOW} : array_data;
            default:                  rd_val = RD_NONE;
        endcase
    end

    // context and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alg_start    <= 1'b0;
            alg_is_erase <= 1'b0;
            alg_sec_mask <= '0;
            paddr_q      <= '0;
            pbit_q       <= 1'b0;
            vmask_q      <= '0;
            pgm_seen_q   <= 1'b0;
            ers_seen_q   <= 1'b0;
            rd_valid     <= 1'b0;
            rd_data      <= RD_NONE;
        end else begin
            alg_start    <= acc_pgm | acc_ers | acc_spgm;
            alg_is_erase <= acc_ers;
            alg_sec_mask <= acc_ers ? eff_mask : '0;
            if (acc_pgm || fake_pgm || acc_spgm) begin
                paddr_q <= cmd_addr;
                pbit_q  <= cmd_dq7;
            end
            if (acc_ers || fake_ers) begin
                if (kind == CMD_CERS) vmask_q <= acc_ers ? ~sec_prot : '1;
                else                  vmask_q <= ers_sel;
            end
            if (acc_pgm || acc_spgm)
                pgm_seen_q <= 1'b0;
            else if ((st_q == ST_PGM_RUN || st_q == ST_SUSP_PGM) && seq_busy)
                pgm_seen_q <= 1'b1;
            if (acc_ers || (st_q == ST_ERS_SUSP && st_d == ST_ERS_RUN))
                ers_seen_q <= 1'b0;
            else if (st_q == ST_ERS_RUN && seq_busy)
                ers_seen_q <= 1'b1;
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_val;
        end
    end

    p_rd_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_prot_pgm_nostart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cmd_start && kind == CMD_PGM && sec_prot[tgt]) |=> !alg_start);

    p_mask_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alg_start |-> ((alg_sec_mask & $past(sec_prot)) == '0));

    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PGM_RUN || st_q == ST_ERS_RUN || st_q == ST_SUSP_PGM ||
         st_q == ST_FAKE_PGM || st_q == ST_FAKE_ERS) |=> !alg_start);

    p_susp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ERS_SUSP && ers_susp && !cmd_start) |=> (st_q == ST_ERS_SUSP));

endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status #(
    parameter int AW      = 20,
    parameter int NSEC    = 16,
    parameter int CLK_MHZ = 50,
    parameter int PGM_US  = 1,
    parameter int ERS_US  = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_start,
    input  logic [1:0]      cmd_kind,
    input  logic [AW-1:0]   cmd_addr,
    input  logic            cmd_dq7,
    input  logic [NSEC-1:0] sec_prot,
    input  logic [NSEC-1:0] ers_sel,
    input  logic            ers_susp,
    input  logic            seq_busy,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    input  logic [7:0]      array_data,
    output logic            alg_start,
    output logic            alg_is_erase,
    output logic [NSEC-1:0] alg_sec_mask,
    output logic            rd_valid,
    output logic [7:0]      rd_data
);

    localparam int SW      = $clog2(NSEC);
    localparam int PGM_WIN = CLK_MHZ * PGM_US;
    localparam int ERS_WIN = CLK_MHZ * ERS_US;
    localparam int MAX_WIN = (ERS_WIN > PGM_WIN) ? ERS_WIN : PGM_WIN;
    localparam int CW      = $clog2(MAX_WIN + 1);

    logic            tmr_load, tmr_expired;
    logic [CW-1:0]   tmr_val;
    logic [AW-1:0]   paddr_q;
    logic [NSEC-1:0] vmask_q;
    logic            pgm_hit, ers_hit;

    fps_win_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    fps_addr_qual #(.AW(AW), .NSEC(NSEC), .SW(SW)) u_qual (
        .rd_addr  (rd_addr),
        .pgm_addr (paddr_q),
        .vmask    (vmask_q),
        .pgm_hit  (pgm_hit),
        .ers_hit  (ers_hit)
    );

    fps_ctrl #(
        .AW(AW), .NSEC(NSEC), .SW(SW), .CW(CW),
        .PGM_WIN(PGM_WIN), .ERS_WIN(ERS_WIN)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .cmd_kind     (cmd_kind),
        .cmd_addr     (cmd_addr),
        .cmd_dq7      (cmd_dq7),
        .sec_prot     (sec_prot),
        .ers_sel      (ers_sel),
        .ers_susp     (ers_susp),
        .seq_busy     (seq_busy),
        .rd_en        (rd_en),
        .array_data   (array_data),
        .pgm_hit      (pgm_hit),
        .ers_hit      (ers_hit),
        .tmr_expired  (tmr_expired),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .paddr_q      (paddr_q),
        .vmask_q      (vmask_q),
        .alg_start    (alg_start),
        .alg_is_erase (alg_is_erase),
        .alg_sec_mask (alg_sec_mask),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data)
    );

endmodule

// File: tb/flash_poll_status_tb_top.sv
`timescale 1ns/1ps
module flash_poll_status_tb_top;

    localparam int AW      = 20;
    localparam int NSEC    = 16;
    localparam int PGM_WIN = 50 * 1;
    localparam int ERS_WIN = 50 * 100;
    localparam logic [7:0] ARR = 8'h5A;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_start = 1'b0;
    logic [1:0]      cmd_kind = 2'b11;
    logic [AW-1:0]   cmd_addr = '0;
    logic            cmd_dq7 = 1'b0;
    logic [NSEC-1:0] sec_prot = '0;
    logic [NSEC-1:0] ers_sel = '0;
    logic            ers_susp = 1'b0;
    logic            seq_busy = 1'b0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic [7:0]      array_data = ARR;
    logic            alg_start, alg_is_erase, rd_valid;
    logic [NSEC-1:0] alg_sec_mask;
    logic [7:0]      rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    flash_poll_status dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_dq7(cmd_dq7), .sec_prot(sec_prot), .ers_sel(ers_sel),
        .ers_susp(ers_susp), .seq_busy(seq_busy), .rd_en(rd_en), .rd_addr(rd_addr),
        .array_data(array_data), .alg_start(alg_start), .alg_is_erase(alg_is_erase),
        .alg_sec_mask(alg_sec_mask), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue_cmd(input logic [1:0] k, input logic [AW-1:0] a, input logic d7);
        cmd_start = 1'b1; cmd_kind = k; cmd_addr = a; cmd_dq7 = d7;
        @(negedge clk);
        cmd_start = 1'b0; cmd_kind = 2'b11;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: compare each answered read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R10 unexpected answer actual=%0h expected=none", rd_data);
            end else begin
                chk({24'h0, rd_data}, {24'h0, exp_q.pop_front()}, tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rd_valid, 0, "R1 rd_valid after reset");
        chk(alg_start, 0, "R1 alg_start after reset");
        rst_n = 1'b1;
        @(negedge clk);
        do_read(20'h1_2345, ARR, "R1 idle read");

        // program, bit7 = 1
        issue_cmd(2'b00, 20'h1_2345, 1'b1);
        chk(alg_start, 1, "R2 program start");
        chk(alg_is_erase, 0, "R2 program kind");
        seq_busy = 1'b1;
        do_read(20'h1_2345, 8'h00, "R2 program status bit7=1");
        do_read(20'h1_2346, 8'hFF, "R9 program foreign address");
        issue_cmd(2'b01, 20'h3_0000, 1'b0);
        chk(alg_start, 0, "R11 command while busy");
        do_read(20'h1_2345, 8'h00, "R11 status unchanged");
        seq_busy = 1'b0;
        @(negedge clk);
        do_read(20'h1_2345, ARR, "R2 program done");

        // program, bit7 = 0
        issue_cmd(2'b00, 20'h2_0001, 1'b0);
        seq_busy = 1'b1;
        do_read(20'h2_0001, 8'h80, "R2 program status bit7=0");
        seq_busy = 1'b0;
        @(negedge clk);
        do_read(20'h2_0001, ARR, "R2 program bit7=0 done");

        // reserved kind in idle
        issue_cmd(2'b11, 20'h0, 1'b0);
        chk(alg_start, 0, "R11 reserved kind");
        do_read(20'h0_0000, ARR, "R11 reserved kind read");

        // sector erase, sectors 1 and 2 selected, 2 protected
        ers_sel = 16'h0006; sec_prot = 16'h0004;
        issue_cmd(2'b01, 20'h1_0000, 1'b0);
        chk(alg_start, 1, "R8 erase start");
        chk(alg_is_erase, 1, "R8 erase kind");
        chk(alg_sec_mask, 32'h0002, "R8 erase mask");
        seq_busy = 1'b1;
        do_read(20'h1_0100, 8'h00, "R3 erase status");
        do_read(20'h2_0100, 8'h00, "R9 selected protected sector");
        do_read(20'h5_0000, 8'hFF, "R9 unselected sector");
        ers_susp = 1'b1; seq_busy = 1'b0;
        @(negedge clk);
        do_read(20'h1_0100, 8'h80, "R4 suspend status");
        do_read(20'h5_0000, ARR, "R4 suspend other sector");
        issue_cmd(2'b00, 20'h7_0010, 1'b1);
        chk(alg_start, 1, "R5 suspend program start");
        chk(alg_is_erase, 0, "R5 suspend program kind");
        seq_busy = 1'b1;
        do_read(20'h7_0010, 8'h00, "R5 suspend program status");
        seq_busy = 1'b0;
        @(negedge clk);
        do_read(20'h1_0100, 8'h80, "R5 back to suspend");
        ers_susp = 1'b0; seq_busy = 1'b1;
        @(negedge clk);
        do_read(20'h1_0100, 8'h00, "R3 resumed erase");
        seq_busy = 1'b0;
        @(negedge clk);
        @(negedge clk);
        do_read(20'h1_0100, ARR, "R3 erase done");

        // chip erase with sector 0 protected
        sec_prot = 16'h0001;
        issue_cmd(2'b10, 20'h0, 1'b0);
        chk(alg_sec_mask, 32'hFFFE, "R8 chip erase mask");
        seq_busy = 1'b1;
        do_read(20'h0_0040, 8'hFF, "R9 chip erase protected sector");
        do_read(20'h3_0040, 8'h00, "R9 chip erase open sector");
        seq_busy = 1'b0;
        @(negedge clk);
        @(negedge clk);

        // program to protected sector
        sec_prot = 16'h0010;
        issue_cmd(2'b00, 20'h4_0000, 1'b1);
        chk(alg_start, 0, "R6 no start");
        do_read(20'h4_0000, 8'h00, "R6 window first");
        repeat (PGM_WIN - 2) @(negedge clk);
        do_read(20'h4_0000, 8'h00, "R6 window last");
        do_read(20'h4_0000, ARR, "R6 after window");

        // erase with only protected sectors selected
        sec_prot = 16'h0100; ers_sel = 16'h0100;
        issue_cmd(2'b01, 20'h8_0000, 1'b0);
        chk(alg_start, 0, "R7 no start");
        do_read(20'h8_0004, 8'h00, "R7 window first");
        repeat (ERS_WIN - 2) @(negedge clk);
        do_read(20'h8_0004, 8'h00, "R7 window last");
        do_read(20'h8_0004, ARR, "R7 after window");

        repeat (3) @(negedge clk);
        chk(exp_q.size(), 0, "R10 all reads answered");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule